// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block holds the live state of one DMA channel while it moves data. It keeps a 16-bit address counter and a 16-bit remaining-count register. Both are loaded in a single cycle. Each accepted transfer step moves the address up by one unit and the count down by one. The block then forms the physical byte address and the byte-lane enables, and raises a memory strobe that matches the transfer kind. An external arbiter calls for each transfer with `stepIn`. The register-write path supplies the load values and the page byte.

A build-time parameter selects a byte channel or a word channel. On a byte channel, the page byte sits above the counter. On a word channel, the counter is shifted up one place, bit 0 of the page is dropped and both byte lanes are enabled. The page is never incremented. An address that runs past the top of its 64 KiB window (128 KiB on a word channel) wraps to the start of the same window.

The count is loaded as the number of transfers minus one. The step that finds the count at zero is the last one. That step raises the terminal-count flag, and the channel goes idle.

Top module: `dmaChanAddrGen`

## Requirements
- R1: After reset the channel is idle, the address counter and remaining count are zero, and no strobe or terminal-count flag is raised.
- R2: With WORD_MODE=0 the physical address is {pageVal[7:0], address counter[15:0]}.
- R3: With WORD_MODE=1 the physical address is {pageVal[7:1], address counter[15:0], 1'b0}, and pageVal bit 0 has no effect.
- R4: Each accepted step adds one to the address counter modulo 2^16, so 16'hFFFF is followed by 16'h0000 and the page bits never change.
- R5: Each accepted step subtracts one from the remaining count. The step taken while the count is zero raises termCount in that same cycle, so a loaded count N yields exactly N+1 steps; 16'hFFFF yields 65536.
- R6: After the terminal step the channel is idle. Later steps change neither the address nor the count, and raise no strobe.
- R7: A step while idle, and any cycle without load or step, leaves address and count unchanged.
- R8: An accepted step raises memWr when xferKind=1 and memRd when xferKind=2. With xferKind 0 (verify) or 3, it raises neither, although the address and count still advance.
- R9: byteEn is 2'b11 on a word channel. On a byte channel it is 2'b01 for an even address and 2'b10 for an odd one.
- R10: loadEn takes priority over stepIn. A load during an active transfer restarts the channel with the new values, and no step is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load address and count, start channel |
| loadAddr | input | 16 | Initial address counter value |
| loadCount | input | 16 | Transfers minus one |
| pageVal | input | 8 | Page byte forming upper address bits |
| xferKind | input | 2 | 0 verify, 1 write memory, 2 read memory, 3 treated as verify |
| stepIn | input | 1 | Request one transfer this cycle |
| physAddr | output | 24 | Physical byte address |
| byteEn | output | 2 | Byte-lane enables {upper, lower} |
| remCount | output | 16 | Remaining count register |
| busy | output | 1 | Channel active |
| memWr | output | 1 | Memory write strobe for an accepted step |
| memRd | output | 1 | Memory read strobe for an accepted step |
| termCount | output | 1 | Terminal step taken this cycle |

## Verification
The assertions assume that reset is asserted before the first edge of interest. They also assume that loadEn, stepIn and xferKind hold known values at every rising edge, since the step-accept and priority checks compare the registers against their previous values. The stimulus changes every input only at the falling edge and always drives defined values. It runs a byte-channel and a word-channel instance side by side with identical inputs and odd page values. It covers idle steps, steps with gaps, the wrap from FFFFh, a mid-transfer reload, every transfer-kind code and a full 65536-step transfer.

// File: rtl/dmaChanPkg.sv
package dmaChanPkg;
  typedef struct packed {
    logic load;
    logic step;
  } pathStb_t;

  typedef enum logic [1:0] {
    XFER_VERIFY  = 2'd0,
    XFER_TOMEM   = 2'd1,
    XFER_FROMMEM = 2'd2,
    XFER_RSVD    = 2'd3
  } xferKind_e;
endpackage

// File: rtl/dmaChanCtl.sv
module dmaChanCtl
  import dmaChanPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       stepIn,
  input  logic [1:0] xferKind,
  input  logic       countZero,
  output pathStb_t   stb,
  output logic       busy,
  output logic       memWr,
  output logic       memRd,
  output logic       termCount
);
  logic busyQ;
  logic accept;

  assign accept    = stepIn && busyQ && !loadEn;
  assign termCount = accept && countZero;
  assign memWr     = accept && (xferKind == XFER_TOMEM);
  assign memRd     = accept && (xferKind == XFER_FROMMEM);
  assign busy      = busyQ;

  always_comb begin
    stb.load = loadEn;
    stb.step = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busyQ <= 1'b0;
    else if (loadEn)    busyQ <= 1'b1;
    else if (termCount) busyQ <= 1'b0;
  end

  // R5
  tc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termCount && !loadEn) |=> !busy);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memWr || memRd || termCount));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWr && memRd));
endmodule

// File: rtl/dmaChanPath.sv
module dmaChanPath
  import dmaChanPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0,
  localparam int PHYS_W   = CNT_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStb_t          stb,
  input  logic [CNT_W-1:0]  loadAddr,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic [PAGE_W-1:0] pageVal,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        byteEn,
  output logic [CNT_W-1:0]  remCount,
  output logic              countZero
);
  logic [CNT_W-1:0] addrCnt;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      cntQ    <= '0;
    end else if (stb.load) begin
      addrCnt <= loadAddr;
      cntQ    <= loadCount;
    end else if (stb.step) begin
      addrCnt <= addrCnt + 1'b1;
      cntQ    <= cntQ - 1'b1;
    end
  end

  assign remCount  = cntQ;
  assign countZero = (cntQ == '0);

  generate
    if (WORD_MODE) begin : g_word
      assign physAddr = {pageVal[PAGE_W-1:1], addrCnt, 1'b0};
      assign byteEn   = 2'b11;
    end else begin : g_byte
      assign physAddr = {pageVal, addrCnt};
      assign byteEn   = addrCnt[0] ? 2'b10 : 2'b01;
    end
  endgenerate

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.load) |=> (addrCnt == $past(addrCnt) + 1'b1));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.load) |=> (cntQ == $past(cntQ) - 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.step && !stb.load) |=> ($stable(addrCnt) && $stable(cntQ)));
endmodule

// File: rtl/dmaChanAddrGen.sv
module dmaChanAddrGen
  import dmaChanPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      loadEn,
  input  logic [CNT_W-1:0]          loadAddr,
  input  logic [CNT_W-1:0]          loadCount,
  input  logic [PAGE_W-1:0]         pageVal,
  input  logic [1:0]                xferKind,
  input  logic                      stepIn,
  output logic [CNT_W+PAGE_W-1:0]   physAddr,
  output logic [1:0]                byteEn,
  output logic [CNT_W-1:0]          remCount,
  output logic                      busy,
  output logic                      memWr,
  output logic                      memRd,
  output logic                      termCount
);
  pathStb_t stb;
  logic     countZero;

  dmaChanCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .stepIn    (stepIn),
    .xferKind  (xferKind),
    .countZero (countZero),
    .stb       (stb),
    .busy      (busy),
    .memWr     (memWr),
    .memRd     (memRd),
    .termCount (termCount)
  );

  dmaChanPath #(
    .CNT_W     (CNT_W),
    .PAGE_W    (PAGE_W),
    .WORD_MODE (WORD_MODE)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .loadAddr  (loadAddr),
    .loadCount (loadCount),
    .pageVal   (pageVal),
    .physAddr  (physAddr),
    .byteEn    (byteEn),
    .remCount  (remCount),
    .countZero (countZero)
  );

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (busy && remCount == $past(loadCount)));
endmodule

// File: tb/dmaChanAddrGen_bench.sv
module dmaChanAddrGen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [15:0] loadAddr = '0;
  logic [15:0] loadCount = '0;
  logic [7:0]  pageVal = '0;
  logic [1:0]  xferKind = '0;
  logic        stepIn = 1'b0;

  logic [23:0] bAddr, wAddr;
  logic [1:0]  bEn, wEn;
  logic [15:0] bRem, wRem;
  logic        bBusy, wBusy, bWr, wWr, bRd, wRd, bTc, wTc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int mAddr = 0, mCnt = 0;
  bit mBusy = 1'b0;

  always #5 clk = ~clk;

  dmaChanAddrGen #(.WORD_MODE(1'b0)) u_dmaChanAddrGen (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadCount(loadCount), .pageVal(pageVal), .xferKind(xferKind),
    .stepIn(stepIn), .physAddr(bAddr), .byteEn(bEn), .remCount(bRem),
    .busy(bBusy), .memWr(bWr), .memRd(bRd), .termCount(bTc));

  dmaChanAddrGen #(.WORD_MODE(1'b1)) u_dmaChanAddrGen_word (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadCount(loadCount), .pageVal(pageVal), .xferKind(xferKind),
    .stepIn(stepIn), .physAddr(wAddr), .byteEn(wEn), .remCount(wRem),
    .busy(wBusy), .memWr(wWr), .memRd(wRd), .termCount(wTc));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    bit acc, tcE;
    logic [23:0] expB, expW;
    acc  = stepIn && mBusy && !loadEn;
    tcE  = acc && (mCnt == 0);
    expB = {pageVal, mAddr[15:0]};
    expW = {pageVal[7:1], mAddr[15:0], 1'b0};
    chk("R2 byte address", bAddr, expB);
    chk("R3 word address", wAddr, expW);
    chk("R5 byte remaining", bRem, mCnt[15:0]);
    chk("R5 word remaining", wRem, mCnt[15:0]);
    chk("R5 byte termCount", bTc, tcE);
    chk("R5 word termCount", wTc, tcE);
    chk("R6 byte busy", bBusy, mBusy);
    chk("R6 word busy", wBusy, mBusy);
    chk("R8 byte memWr", bWr, acc && xferKind == 2'd1);
    chk("R8 byte memRd", bRd, acc && xferKind == 2'd2);
    chk("R8 word memWr", wWr, acc && xferKind == 2'd1);
    chk("R8 word memRd", wRd, acc && xferKind == 2'd2);
    chk("R9 byte lanes", bEn, mAddr[0] ? 2'b10 : 2'b01);
    chk("R9 word lanes", wEn, 2'b11);
  endtask

  task automatic cyc(input bit ld, input bit st, input logic [15:0] a,
                     input logic [15:0] c, input logic [1:0] k);
    @(negedge clk);
    loadEn = ld; stepIn = st; loadAddr = a; loadCount = c; xferKind = k;
    #1;
    compareAll();
    @(posedge clk);
    cycles++;
    if (!rstN) begin
      mAddr = 0; mCnt = 0; mBusy = 1'b0;
    end else if (ld) begin
      mAddr = a; mCnt = c; mBusy = 1'b1;
    end else if (st && mBusy) begin
      mAddr = (mAddr + 1) & 16'hFFFF;
      if (mCnt == 0) mBusy = 1'b0;
      mCnt = (mCnt - 1) & 16'hFFFF;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tcSeen;
    pageVal = 8'h35;
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(0, 0, 16'h0, 16'h0, 2'd0);
    @(negedge clk); #1;
    chk("R1 reset busy", bBusy, 1'b0);
    chk("R1 reset remaining", bRem, 16'h0);
    chk("R1 reset address", bAddr, 24'h350000);
    rstN = 1'b1;

    // R7: steps while idle change nothing
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    cyc(0, 1, 16'h0, 16'h0, 2'd2);
    @(negedge clk); #1;
    chk("R7 idle step address", bAddr, 24'h350000);

    // R5 R6 R8: write transfer of three with gaps, then ignored steps
    cyc(1, 0, 16'h1234, 16'd2, 2'd1);
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    cyc(0, 0, 16'h0, 16'h0, 2'd1);
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    @(negedge clk); #1;
    chk("R6 address frozen after end", bAddr, 24'h351237);

    // R4: wrap inside the block, verify kind, odd page for R3
    pageVal = 8'h81;
    cyc(1, 0, 16'hFFFE, 16'd3, 2'd0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 16'h0, 16'h0, 2'd0);
    @(negedge clk); #1;
    chk("R4 byte wrap", bAddr, 24'h810002);
    chk("R4 word wrap", wAddr, 24'h800004);

    // R10: reload during a read transfer
    cyc(1, 0, 16'h0010, 16'd5, 2'd2);
    cyc(0, 1, 16'h0, 16'h0, 2'd2);
    cyc(0, 1, 16'h0, 16'h0, 2'd2);
    cyc(1, 1, 16'h0500, 16'd1, 2'd2);
    @(negedge clk); #1;
    chk("R10 reload address", bAddr, 24'h810500);
    chk("R10 reload count", bRem, 16'd1);
    for (int i = 0; i < 3; i++) cyc(0, 1, 16'h0, 16'h0, 2'd2);

    // R8: kind 3 behaves as verify; single transfer count 0
    cyc(1, 0, 16'h0007, 16'd0, 2'd3);
    cyc(0, 1, 16'h0, 16'h0, 2'd3);
    cyc(0, 1, 16'h0, 16'h0, 2'd3);

    // R5: loaded FFFFh gives 65536 transfers
    pageVal = 8'h12;
    cyc(1, 0, 16'hABCD, 16'hFFFF, 2'd1);
    tcSeen = 0;
    for (int i = 0; i < 65536; i++) begin
      cyc(0, 1, 16'h0, 16'h0, 2'd1);
      if (bTc) tcSeen = i + 1;
    end
    chk("R5 full transfer length", tcSeen, 65536);
    cyc(0, 1, 16'h0, 16'h0, 2'd1);
    @(negedge clk); #1;
    chk("R6 idle after full transfer", bBusy, 1'b0);
    chk("R4 full wrap back to start", bAddr, 24'h12ABCD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule